// File: doc/BRIEF.md
# Instruction-Set Mode Gate with Countdown

This block sits next to an instruction decoder and decides, for every retiring instruction, whether the extension that instruction belongs to is currently enabled. It holds one mode word that has three fields. The first is a set of unary enable bits, one per extension. The second is a binary flavour field that selects one of several mutually exclusive instruction-set variants. The third is a countdown. Some extensions are governed by the countdown: they are usable only while it is nonzero. A countdown loaded with N therefore opens those extensions for exactly N retired instructions, and they then close again without any further write.

Software writes the mode word through a single write port. Fields marked privileged can be changed only in supervisor state. A user-state write that would alter a privileged field is dropped as a whole and reported. The remaining fields can be written from user state directly. When a trap is taken, the live mode word, including the running count, is copied into a save register and the countdown is cleared. A trap return restores the saved word. Every retiring instruction can raise one of three trap causes, reported one cycle later: illegal extension, a non-sequential program-counter change while the count is live, or a privileged-field write attempted from user state.

Top module: `isa_mode_gate`

## Requirements
- R1: Extension ID 0 (base instruction set) is always legal. IDs above the highest defined ID (8 to 15 with the default parameters) are never legal.
- R2: Extension IDs 1 to 4 map to enable bits 0 to 3 of the mode word. ID k+1 is legal only when enable bit k is 1.
- R3: Extension IDs 5 to 7 are the flavour instructions. ID 4+f is legal only when the flavour field (bits [5:4]) equals f.
- R4: When an instruction retires with an extension that is not legal, trap_cause_o reads 1 (illegal) and trap_o reads 1 in the cycle after it retires. Both return to 0 afterwards unless a new trap occurs.
- R5: A mode write changes legality from the next cycle's instruction onward. An instruction that retires in the same cycle as the write is judged against the old word.
- R6: The mode word is laid out as enables in bits [3:0], flavour in bits [5:4] and countdown in bits [9:6]. It resets to all zeros. A supervisor-state write replaces the whole word.
- R7: Enable bits 0 and 1 and the flavour field are privileged. A user-state write that would change any of them leaves the mode word unchanged, and trap_cause_o reads 3 for one cycle.
- R8: A user-state write that leaves the privileged bits at their current value is applied in full, and no trap is raised.
- R9: Enable bits 2 and 3 are governed by the countdown: IDs 3 and 4 are legal only while the countdown is nonzero. The countdown drops by one for each retired instruction and holds while no instruction retires. A load of N therefore leaves those IDs legal for exactly N retirements.
- R10: A retiring instruction with a non-sequential next PC raises cause 2 (flow) while the countdown is nonzero. It raises no trap while the countdown is zero.
- R11: A trap-entry strobe copies the mode word into the save register and clears the countdown. A trap-return strobe reloads the mode word from the save register.
- R12: When several causes coincide, illegal (1) takes priority over flow (2), which takes priority over privileged (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ret_valid_i | input | 1 | An instruction retires this cycle (low while stalled) |
| ret_seq_i | input | 1 | The retiring instruction's next PC is sequential |
| ret_ext_i | input | EXT_W | Decoded extension ID of the current instruction |
| sup_i | input | 1 | Supervisor state |
| wr_en_i | input | 1 | Mode word write strobe |
| wr_data_i | input | W | Mode word write value |
| trap_enter_i | input | 1 | Trap entry strobe |
| trap_return_i | input | 1 | Trap return strobe |
| ext_legal_o | output | 1 | The current extension ID is enabled |
| mode_o | output | W | Live mode word |
| save_o | output | W | Saved mode word |
| trap_o | output | 1 | A trap cause was raised last cycle |
| trap_cause_o | output | 2 | 0 none, 1 illegal, 2 flow, 3 privileged |

## Verification
The bench loads every enable and flavour combination, with the countdown both zero and live, and compares the legality of every extension ID against a computed model. This catches a decoder that is off by one between IDs and bits, or one that ignores the countdown gate on bits 2 and 3. It also counts a countdown through its retirements with a stall cycle in between, so a design that decrements on idle cycles or allows N+1 instructions is detected. Same-cycle write and retire, user writes that touch privileged bits, overlapping trap causes, and a save and restore around a trap are each driven directly. A design that applies a write early, merges a rejected write, ranks the causes in the wrong order, or loses the running count across a trap would report the wrong cause or the wrong word.

// File: rtl/isa_mode_pkg.sv
package isa_mode_pkg;
   timeunit 1ns; timeprecision 10ps;

   // Trap cause encoding reported one cycle after the offending retirement.
   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'd0,
      CAUSE_ILLEGAL = 2'd1,
      CAUSE_FLOW    = 2'd2,
      CAUSE_PRIV    = 2'd3
   } cause_e;
endpackage

// File: rtl/isa_mode_legal.sv
module isa_mode_legal #(
   parameter int N_UNARY = 4,
   parameter int SEL_W   = 2,
   parameter int CNT_W   = 4,
   parameter int EXT_W   = 4,
   parameter logic [N_UNARY-1:0] CD_MASK = 4'b1100
) (
   input  logic [N_UNARY-1:0] en_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic [CNT_W-1:0]   cnt_i,
   input  logic [EXT_W-1:0]   ext_i,
   output logic               legal_o
);
   timeunit 1ns; timeprecision 10ps;

   localparam int N_FLAV = 2**SEL_W;

   logic              cnt_live;
   logic [N_UNARY-1:0] unary_ok;

   assign cnt_live = (cnt_i != '0);

   // Each unary bit is either free-standing or gated by the countdown.
   for (genvar k = 0; k < N_UNARY; k++) begin : g_unary
      if (CD_MASK[k]) begin : g_counted
         assign unary_ok[k] = en_i[k] & cnt_live;
      end else begin : g_plain
         assign unary_ok[k] = en_i[k];
      end
   end

   always_comb begin
      legal_o = 1'b0;
      if (ext_i == '0) legal_o = 1'b1;
      for (int k = 0; k < N_UNARY; k++) begin
         if (ext_i == EXT_W'(k + 1)) legal_o = unary_ok[k];
      end
      for (int f = 1; f < N_FLAV; f++) begin
         if (ext_i == EXT_W'(N_UNARY + f)) legal_o = (sel_i == SEL_W'(f));
      end
   end
endmodule

// File: rtl/isa_mode_state.sv
module isa_mode_state #(
   parameter int N_UNARY = 4,
   parameter int SEL_W   = 2,
   parameter int CNT_W   = 4,
   parameter logic [N_UNARY-1:0] PRIV_UNARY = 4'b0011,
   parameter bit SEL_PRIV = 1'b1,
   localparam int W = N_UNARY + SEL_W + CNT_W
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_en_i,
   input  logic [W-1:0] wr_data_i,
   input  logic         sup_i,
   input  logic         ret_valid_i,
   input  logic         enter_i,
   input  logic         leave_i,
   output logic [W-1:0] word_o,
   output logic [W-1:0] save_o,
   output logic         priv_viol_o
);
   timeunit 1ns; timeprecision 10ps;

   localparam int LOW_W = N_UNARY + SEL_W;
   localparam logic [W-1:0] PRIV_BITS = {{CNT_W{1'b0}}, {SEL_W{SEL_PRIV}}, PRIV_UNARY};

   logic [W-1:0]     word_q, word_d, save_q;
   logic [CNT_W-1:0] cnt;

   assign cnt = word_q[W-1 -: CNT_W];
   assign priv_viol_o = wr_en_i & ~sup_i & (((wr_data_i ^ word_q) & PRIV_BITS) != '0);

   always_comb begin
      word_d = word_q;
      if (enter_i) begin
         word_d = {{CNT_W{1'b0}}, word_q[LOW_W-1:0]};
      end else if (leave_i) begin
         word_d = save_q;
      end else if (wr_en_i && !priv_viol_o) begin
         word_d = wr_data_i;
      end else if (ret_valid_i && cnt != '0) begin
         word_d[W-1 -: CNT_W] = cnt - 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= '0;
         save_q <= '0;
      end else begin
         word_q <= word_d;
         if (enter_i) save_q <= word_q;
      end
   end

   assign word_o = word_q;
   assign save_o = save_q;

   // R9: one step down per retirement while live
   a_r9_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_valid_i && !wr_en_i && !enter_i && !leave_i && cnt != '0)
      |=> (word_q[W-1 -: CNT_W] == $past(cnt) - 1'b1));
   // R9: nothing moves on an idle cycle
   a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ret_valid_i && !wr_en_i && !enter_i && !leave_i) |=> $stable(word_q));
   // R7: a rejected user write leaves the word as it was
   a_r7_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (priv_viol_o && !ret_valid_i && !enter_i && !leave_i) |=> $stable(word_q));
   // R11: entry snapshots the word, return brings it back
   a_r11_save: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enter_i |=> (save_o == $past(word_q)));
   a_r11_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (leave_i && !enter_i) |=> (word_q == $past(save_q)));
   a_r11_save_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enter_i |=> $stable(save_q));
endmodule

// File: rtl/isa_mode_gate.sv
module isa_mode_gate
   import isa_mode_pkg::*;
#(
   parameter int N_UNARY = 4,
   parameter int SEL_W   = 2,
   parameter int CNT_W   = 4,
   parameter int EXT_W   = 4,
   parameter logic [N_UNARY-1:0] PRIV_UNARY = 4'b0011,
   parameter logic [N_UNARY-1:0] CD_MASK    = 4'b1100,
   parameter bit SEL_PRIV = 1'b1,
   localparam int W = N_UNARY + SEL_W + CNT_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ret_valid_i,
   input  logic             ret_seq_i,
   input  logic [EXT_W-1:0] ret_ext_i,
   input  logic             sup_i,
   input  logic             wr_en_i,
   input  logic [W-1:0]     wr_data_i,
   input  logic             trap_enter_i,
   input  logic             trap_return_i,
   output logic             ext_legal_o,
   output logic [W-1:0]     mode_o,
   output logic [W-1:0]     save_o,
   output logic             trap_o,
   output logic [1:0]       trap_cause_o
);
   timeunit 1ns; timeprecision 10ps;

   localparam int EXT_MIN = $clog2(N_UNARY + 2**SEL_W);

   if (EXT_W < EXT_MIN) begin : g_chk_ext
      $error("EXT_W too narrow for the defined extension IDs");
   end
   if (N_UNARY < 1 || SEL_W < 1 || CNT_W < 1) begin : g_chk_fields
      $error("every mode field needs at least one bit");
   end

   logic [W-1:0]     word, save;
   logic [CNT_W-1:0] cnt;
   logic             priv_viol, flow_viol, ill_viol;
   cause_e           cause_d, cause_q;

   isa_mode_state #(
      .N_UNARY(N_UNARY), .SEL_W(SEL_W), .CNT_W(CNT_W),
      .PRIV_UNARY(PRIV_UNARY), .SEL_PRIV(SEL_PRIV)
   ) state_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .sup_i(sup_i),
      .ret_valid_i(ret_valid_i), .enter_i(trap_enter_i), .leave_i(trap_return_i),
      .word_o(word), .save_o(save), .priv_viol_o(priv_viol)
   );

   assign cnt = word[W-1 -: CNT_W];

   isa_mode_legal #(
      .N_UNARY(N_UNARY), .SEL_W(SEL_W), .CNT_W(CNT_W),
      .EXT_W(EXT_W), .CD_MASK(CD_MASK)
   ) legal_i (
      .en_i(word[N_UNARY-1:0]),
      .sel_i(word[N_UNARY +: SEL_W]),
      .cnt_i(cnt),
      .ext_i(ret_ext_i),
      .legal_o(ext_legal_o)
   );

   assign ill_viol  = ret_valid_i & ~ext_legal_o;
   assign flow_viol = ret_valid_i & ~ret_seq_i & (cnt != '0);

   always_comb begin
      if (ill_viol)       cause_d = CAUSE_ILLEGAL;
      else if (flow_viol) cause_d = CAUSE_FLOW;
      else if (priv_viol) cause_d = CAUSE_PRIV;
      else                cause_d = CAUSE_NONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q <= CAUSE_NONE;
      else         cause_q <= cause_d;
   end

   assign trap_cause_o = cause_q;
   assign trap_o       = (cause_q != CAUSE_NONE);
   assign mode_o       = word;
   assign save_o       = save;

   // R1: base instructions never gated
   a_r1_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_ext_i == '0) |-> ext_legal_o);
   // R4: illegal retirement reported next cycle
   a_r4_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_valid_i && !ext_legal_o) |=> (trap_cause_o == CAUSE_ILLEGAL));
   // R10: live count crossed by a jump
   a_r10_flow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_valid_i && ext_legal_o && !ret_seq_i && cnt != '0)
      |=> (trap_cause_o == CAUSE_FLOW));
   // R9: counted extensions shut once the count is spent
   a_r9_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt == '0 && ret_ext_i == EXT_W'(N_UNARY)
       && CD_MASK[N_UNARY-1]) |-> !ext_legal_o);
endmodule

// File: tb/isa_mode_gate_tb_top.sv
module isa_mode_gate_tb_top;
   timeunit 1ns; timeprecision 10ps;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       rv, seq, sup, we, ent, lv;
   logic [3:0] ext;
   logic [9:0] wd;
   logic       legal, trap;
   logic [9:0] mode, save;
   logic [1:0] cause;

   int n_chk = 0;
   int n_fail = 0;

   isa_mode_gate dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ret_valid_i(rv), .ret_seq_i(seq),
      .ret_ext_i(ext), .sup_i(sup), .wr_en_i(we), .wr_data_i(wd),
      .trap_enter_i(ent), .trap_return_i(lv), .ext_legal_o(legal),
      .mode_o(mode), .save_o(save), .trap_o(trap), .trap_cause_o(cause)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Legality model from R1, R2, R3, R9.
   function automatic int model_legal(input logic [9:0] w, input int id);
      int c = int'(w[9:6]);
      if (id == 0) return 1;
      if (id >= 1 && id <= 4) begin
         if (id >= 3) return int'(w[id-1] && c != 0);
         return int'(w[id-1]);
      end
      if (id >= 5 && id <= 7) return int'(int'(w[5:4]) == id - 4);
      return 0;
   endfunction

   task automatic idle();
      rv = 0; seq = 1; ext = 0; sup = 0; we = 0; wd = '0; ent = 0; lv = 0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic swr(input logic [9:0] v);
      idle(); sup = 1; we = 1; wd = v; tick(); idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle();
      repeat (2) tick();
      rst_n = 1'b1;
      tick();

      // R6 reset state
      check("R6 reset mode", int'(mode), 0);
      check("R6 reset save", int'(save), 0);
      check("R4 reset trap", int'(trap), 0);

      // R1 R2 R3 R9 R6: sweep every enable/flavour pair, countdown dead and live
      for (int cv = 0; cv < 2; cv++) begin
         for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 16; e++) begin
               logic [9:0] w;
               w = {(cv == 1) ? 4'd3 : 4'd0, 2'(s), 4'(e)};
               swr(w);
               check("R6 supervisor write", int'(mode), int'(w));
               for (int id = 0; id < 16; id++) begin
                  ext = 4'(id);
                  #0.05;
                  check($sformatf("R1/R2/R3/R9 legal id=%0d word=%0h", id, w),
                        int'(legal), model_legal(w, id));
               end
               ext = 0;
            end
         end
      end

      // R4 illegal retire, then clears
      swr(10'd0);
      rv = 1; ext = 4'd9; tick(); idle();
      check("R4 cause illegal", int'(cause), 1);
      check("R4 trap high", int'(trap), 1);
      tick();
      check("R4 cause clears", int'(cause), 0);

      // R5 write and retire in the same cycle
      sup = 1; we = 1; wd = 10'b0000_00_0001; rv = 1; ext = 4'd1; tick(); idle();
      check("R5 same-cycle uses old word", int'(cause), 1);
      rv = 1; ext = 4'd1; tick(); idle();
      check("R5 next cycle uses new word", int'(cause), 0);

      // R7 user write to privileged bits rejected
      swr(10'd0);
      we = 1; wd = 10'b0000_01_0001; tick(); idle();
      check("R7 word unchanged", int'(mode), 0);
      check("R7 cause priv", int'(cause), 3);
      tick();
      check("R7 pulse one cycle", int'(cause), 0);

      // R8 user write to free bits applied
      we = 1; wd = {4'd5, 2'd0, 4'b1000}; tick(); idle();
      check("R8 word applied", int'(mode), int'({4'd5, 2'd0, 4'b1000}));
      check("R8 no trap", int'(cause), 0);

      // R10 jump while live, and while dead
      rv = 1; seq = 0; ext = 0; tick(); idle();
      check("R10 flow cause", int'(cause), 2);
      check("R10 count still steps", int'(mode[9:6]), 4);
      swr(10'd0);
      rv = 1; seq = 0; tick(); idle();
      check("R10 no trap when count zero", int'(cause), 0);

      // R9 countdown of exactly three, with a stall in the middle
      swr({4'd3, 2'd0, 4'b0100});
      for (int i = 0; i < 3; i++) begin
         rv = 1; ext = 4'd3; #0.05;
         check($sformatf("R9 counted id legal step %0d", i), int'(legal), 1);
         tick(); idle();
         check($sformatf("R9 count after step %0d", i), int'(mode[9:6]), 2 - i);
         check($sformatf("R9 no trap step %0d", i), int'(cause), 0);
         if (i == 0) begin
            tick();
            check("R9 stall holds count", int'(mode[9:6]), 2);
         end
      end
      ext = 4'd3; #0.05;
      check("R9 closed after count", int'(legal), 0);
      check("R9 enable bit retained", int'(mode[2]), 1);
      rv = 1; tick(); idle();
      check("R9 extra retire traps", int'(cause), 1);

      // R12 priorities
      swr({4'd3, 2'd0, 4'd0});
      rv = 1; seq = 0; ext = 4'd9; tick(); idle();
      check("R12 illegal over flow", int'(cause), 1);
      rv = 1; seq = 0; ext = 0; we = 1; wd = 10'b0000_00_0001; tick(); idle();
      check("R12 flow over priv", int'(cause), 2);
      check("R12 rejected write, count stepped", int'(mode), int'({4'd1, 2'd0, 4'd0}));

      // R11 save and restore across a trap
      swr({4'd6, 2'd2, 4'b1101});
      ent = 1; tick(); idle();
      check("R11 save copy", int'(save), int'({4'd6, 2'd2, 4'b1101}));
      check("R11 count cleared", int'(mode), int'({4'd0, 2'd2, 4'b1101}));
      swr(10'd0);
      lv = 1; tick(); idle();
      check("R11 restore", int'(mode), int'({4'd6, 2'd2, 4'b1101}));

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule